// File: doc/BRIEF.md
# Dual-Enable Static RAM with Separate Data Buses

This block is a clocked, synthesizable model of a 4096-word by 4-bit static RAM. It has one 4-bit input bus and a separate 4-bit output bus. An active-low select gates every access. The write strobe is formed inside the block from two active-low enables: a write is in progress only while both enables are low. The stored word is committed when that strobe ends.

The outputs are never tri-stated. They are driven to zero while the RAM is deselected and while a write strobe is active. Read data appears a configurable number of cycles after the address settles. A valid flag runs beside the data, so the window in which the data is undefined is seen as a deterministic "not valid" state rather than as random values.

A write whose address or select moves while the strobe is low is dropped. A one-cycle error pulse then reports the dropped write. A host uses the block the same way it would use an asynchronous RAM, with every input sampled on the rising clock edge.

Top module: `sepio_sram`

## Requirements
- R1: After reset every one of the 4096 words reads as zero, and reset leaves `dout` = 0, `dout_valid` = 0 and `wr_abort` = 0.
- R2: A clock edge that samples `sel_n` high drives `dout` to 0 and `dout_valid` to 0 after that edge.
- R3: A clock edge at which `sel_n` is low and at least one of `wen_a_n`/`wen_b_n` is high is a read. A single low enable never changes the array.
- R4: A write strobe exists at every edge where `wen_a_n` and `wen_b_n` are both low. After each such edge, `dout` = 0 and `dout_valid` = 0. A strobe that begins with `sel_n` high writes nothing and raises no error.
- R5: For a strobe that begins with `sel_n` low, the stored word is the `din` sampled at the last edge at which both enables were low. It is written at the first edge that sees the strobe released. `din` at the release edge is ignored.
- R6: Let a read address be first sampled at edge e0 (the previous edge was not a read of the same address). Then `dout`/`dout_valid` read 0/0 after edges e0 .. e0+RD_LAT-1, and they present the stored word with `dout_valid` = 1 after edge e0+RD_LAT, provided the address and select stay unchanged.
- R7: The strobe may end with `sel_n` still low and the same address as the committed write. In that case, after the release edge the outputs are 0/0, and the new word is valid WR_REC edges after the release edge.
- R8: An address change during a read holds the previous `dout` and `dout_valid` for one edge. The outputs then read 0/0 until R6 is met for the new address.
- R9: A write is dropped if, at any edge inside the strobe, the address differs from the one sampled at the first strobe edge or `sel_n` is high. `wr_abort` is then 1 for exactly the one cycle after the release edge, and neither address changes.
- R10: Whenever `dout_valid` is 0, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset, clears array and outputs |
| sel_n | input | 1 | Active-low select |
| wen_a_n | input | 1 | First active-low write enable |
| wen_b_n | input | 1 | Second active-low write enable |
| addr | input | 12 | Word address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data, zero when not valid |
| dout_valid | output | 1 | High when `dout` carries a settled word |
| wr_abort | output | 1 | One-cycle pulse after a dropped write |

## Verification
A corrupted word in the array shows up only when that address is read back. The bench therefore keeps a shadow copy and compares every read against it, including reads of words that dropped writes must not have touched. A wrong age count or recovery flag moves the cycle in which `dout_valid` rises, so the latency, recovery and hold tests sample every cycle of the window rather than only its end. A wrong write-phase state shows within one cycle of the release edge, either as a missing or extra `wr_abort` pulse or as the wrong word on the next read.

// File: rtl/sepio_sram_pkg.sv
package sepio_sram_pkg;

   // Phase of the write controller across one strobe.
   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,  // no strobe, or strobe began deselected
      PH_ARMED   = 2'd1,  // strobe began selected, address captured
      PH_SPOILED = 2'd2   // address or select moved inside the strobe
   } wr_phase_e;

   function automatic int unsigned age_width(input int unsigned lat);
      return (lat < 1) ? 1 : $clog2(lat + 1);
   endfunction

endpackage

// File: rtl/sepio_sram_array.sv
module sepio_sram_array #(
   parameter int unsigned AW = 12,
   parameter int unsigned DW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/sepio_sram_wr_ctrl.sv
module sepio_sram_wr_ctrl
   import sepio_sram_pkg::*;
#(
   parameter int unsigned AW = 12,
   parameter int unsigned DW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n,
   input  logic          strobe,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic          commit,
   output logic          release_edge,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          abort_q
);
   wr_phase_e     phase;
   logic          strobe_q;
   logic          strobe_start;
   logic          addr_moved;

   assign strobe_start = strobe & ~strobe_q;
   assign release_edge = ~strobe & strobe_q;
   assign addr_moved   = (addr != wr_addr);
   assign commit       = release_edge & (phase == PH_ARMED);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         phase    <= PH_IDLE;
         wr_addr  <= '0;
         wr_data  <= '0;
         abort_q  <= 1'b0;
      end else begin
         strobe_q <= strobe;
         abort_q  <= release_edge & (phase == PH_SPOILED);
         if (strobe_start) begin
            phase   <= sel_n ? PH_IDLE : PH_ARMED;
            wr_addr <= addr;
            wr_data <= din;
         end else if (strobe) begin
            wr_data <= din;
            if (phase == PH_ARMED && (sel_n || addr_moved))
               phase <= PH_SPOILED;
         end else if (release_edge) begin
            phase <= PH_IDLE;
         end
      end
   end

endmodule

// File: rtl/sepio_sram_rd_pipe.sv
module sepio_sram_rd_pipe
   import sepio_sram_pkg::*;
#(
   parameter int unsigned AW       = 12,
   parameter int unsigned DW       = 4,
   parameter int unsigned RD_LAT   = 2,
   parameter int unsigned WR_REC   = 1,
   parameter bit          OUT_HOLD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd,
   input  logic [AW-1:0] addr,
   input  logic          rec_set,
   input  logic [DW-1:0] rdata,
   output logic [DW-1:0] dout,
   output logic          dout_valid
);
   localparam int unsigned AGW = age_width(RD_LAT);
   localparam logic [AGW-1:0] LAT_C = AGW'(RD_LAT);
   localparam logic [AGW-1:0] REC_C = AGW'(WR_REC);

   logic          rd_q;
   logic [AW-1:0] addr_q;
   logic [AGW-1:0] age;
   logic [AGW-1:0] age_n;
   logic [AGW-1:0] thr;
   logic          rec;
   logic          same;
   logic          moved;
   logic [DW-1:0] dout_n;
   logic          valid_n;
   logic          keep;

   assign same  = rd & rd_q & (addr == addr_q);
   assign moved = rd & rd_q & (addr != addr_q);
   assign age_n = !same ? '0 : ((age == LAT_C) ? age : age + 1'b1);
   assign thr   = rec ? REC_C : LAT_C;

   generate
      if (OUT_HOLD) begin : g_hold
         assign keep = moved;
      end else begin : g_nohold
         assign keep = 1'b0;
      end
   endgenerate

   always_comb begin
      dout_n  = '0;
      valid_n = 1'b0;
      if (keep) begin
         dout_n  = dout;
         valid_n = dout_valid;
      end else if (same && age_n >= thr) begin
         dout_n  = rdata;
         valid_n = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q       <= 1'b0;
         addr_q     <= '0;
         age        <= '0;
         rec        <= 1'b0;
         dout       <= '0;
         dout_valid <= 1'b0;
      end else begin
         rd_q       <= rd;
         addr_q     <= addr;
         age        <= age_n;
         rec        <= rec_set | (same & rec);
         dout       <= dout_n;
         dout_valid <= valid_n;
      end
   end

endmodule

// File: rtl/sepio_sram.sv
module sepio_sram
   import sepio_sram_pkg::*;
#(
   parameter int unsigned AW       = 12,
   parameter int unsigned DW       = 4,
   parameter int unsigned RD_LAT   = 2,
   parameter int unsigned WR_REC   = 1,
   parameter bit          OUT_HOLD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n,
   input  logic          wen_a_n,
   input  logic          wen_b_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic          dout_valid,
   output logic          wr_abort
);
   generate
      if (AW < 1 || AW > 16) begin : g_bad_aw
         $error("sepio_sram: AW must lie in 1..16");
      end
      if (DW < 1) begin : g_bad_dw
         $error("sepio_sram: DW must be at least 1");
      end
      if (RD_LAT < 1 || WR_REC < 1 || WR_REC > RD_LAT) begin : g_bad_lat
         $error("sepio_sram: need 1 <= WR_REC <= RD_LAT");
      end
   endgenerate

   logic          strobe;
   logic          rd;
   logic          commit;
   logic          release_edge;
   logic          rec_set;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic [DW-1:0] rdata;

   assign strobe  = ~wen_a_n & ~wen_b_n;
   assign rd      = ~sel_n & ~strobe;
   assign rec_set = commit & ~sel_n & (addr == wr_addr);

   sepio_sram_wr_ctrl #(.AW(AW), .DW(DW)) u_wr (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_n        (sel_n),
      .strobe       (strobe),
      .addr         (addr),
      .din          (din),
      .commit       (commit),
      .release_edge (release_edge),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .abort_q      (wr_abort)
   );

   sepio_sram_array #(.AW(AW), .DW(DW)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (commit),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (addr),
      .rdata (rdata)
   );

   sepio_sram_rd_pipe #(
      .AW(AW), .DW(DW), .RD_LAT(RD_LAT), .WR_REC(WR_REC), .OUT_HOLD(OUT_HOLD)
   ) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd         (rd),
      .addr       (addr),
      .rec_set    (rec_set),
      .rdata      (rdata),
      .dout       (dout),
      .dout_valid (dout_valid)
   );

endmodule

// File: rtl/sepio_sram_chk.sv
module sepio_sram_chk #(
   parameter int unsigned AW = 12,
   parameter int unsigned DW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sel_n,
   input logic          wen_a_n,
   input logic          wen_b_n,
   input logic [AW-1:0] addr,
   input logic [DW-1:0] dout,
   input logic          dout_valid,
   input logic          wr_abort
);
   a_r2_desel_zero: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |=> (dout == '0 && !dout_valid));

   a_r4_strobe_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!wen_a_n && !wen_b_n) |=> (dout == '0 && !dout_valid));

   a_r10_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_valid |-> dout == '0);

   a_r6_rise_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_valid) |-> $past(addr) == $past(addr, 2));

   a_r9_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_abort |=> !wr_abort);

   a_r9_abort_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      wr_abort |-> $past(wen_a_n || wen_b_n));

endmodule

bind sepio_sram sepio_sram_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel_n      (sel_n),
   .wen_a_n    (wen_a_n),
   .wen_b_n    (wen_b_n),
   .addr       (addr),
   .dout       (dout),
   .dout_valid (dout_valid),
   .wr_abort   (wr_abort)
);

// File: tb/sim_sepio_sram.sv
module sim_sepio_sram;
   localparam int LAT = 2;
   localparam int REC = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1;
   logic        wen_a_n = 1'b1;
   logic        wen_b_n = 1'b1;
   logic [11:0] addr = '0;
   logic [3:0]  din = '0;
   logic [3:0]  dout;
   logic        dout_valid;
   logic        wr_abort;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [3:0] shadow [4096];

   sepio_sram u0 (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wen_a_n(wen_a_n),
      .wen_b_n(wen_b_n), .addr(addr), .din(din), .dout(dout),
      .dout_valid(dout_valid), .wr_abort(wr_abort)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         total++; bad++;
         $display("FAIL watchdog: run hung, act=%0d exp=<100000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: act={valid=%b,data=%h} exp={valid=%b,data=%h}",
                  req, act[4], act[3:0], exp[4], exp[3:0]);
      end
   endtask

   task automatic chk_abort(input string req, input logic exp);
      total++;
      if (wr_abort !== exp) begin
         bad++;
         $display("FAIL %s: wr_abort act=%b exp=%b", req, wr_abort, exp);
      end
   endtask

   task automatic go_idle();
      sel_n = 1'b1; wen_a_n = 1'b1; wen_b_n = 1'b1;
      tick();
   endtask

   task automatic read_word(input logic [11:0] a, input string req);
      sel_n = 1'b0; wen_a_n = 1'b1; wen_b_n = 1'b1; addr = a;
      repeat (LAT + 1) tick();
      chk(req, {dout_valid, dout}, {1'b1, shadow[a]});
   endtask

   // two-cycle strobe; din changes inside and at release (R5)
   task automatic write_word(input logic [11:0] a, input logic [3:0] d);
      sel_n = 1'b0; addr = a; din = ~d; wen_a_n = 1'b0; wen_b_n = 1'b0;
      tick();
      chk("R4 outputs zero during strobe", {dout_valid, dout}, 5'h00);
      din = d;
      tick();
      wen_a_n = 1'b1; wen_b_n = 1'b1; din = d ^ 4'h5;
      tick();
      shadow[a] = d;
   endtask

   task automatic t_reset();
      chk("R1 reset outputs", {dout_valid, dout}, 5'h00);
      chk_abort("R1 reset abort", 1'b0);
      read_word(12'h000, "R1 word 0 zero");
      read_word(12'hFFF, "R1 last word zero");
   endtask

   task automatic t_latency();
      go_idle();
      sel_n = 1'b0; addr = 12'h0A0;
      tick(); chk("R6 after e0", {dout_valid, dout}, 5'h00);
      tick(); chk("R6 after e0+1", {dout_valid, dout}, 5'h00);
      tick(); chk("R6 after e0+LAT", {dout_valid, dout}, {1'b1, shadow[12'h0A0]});
   endtask

   task automatic t_recovery();
      write_word(12'h123, 4'h9);
      chk("R7 release edge zero", {dout_valid, dout}, 5'h00);
      tick();
      chk("R7 valid after WR_REC", {dout_valid, dout}, 5'h19);
      read_word(12'h124, "R7 neighbour untouched");
   endtask

   task automatic t_late_data();
      write_word(12'h0A0, 4'hC);
      read_word(12'h0A0, "R5 last in-strobe din stored");
   endtask

   task automatic t_hold();
      write_word(12'h200, 4'h3);
      write_word(12'h201, 4'hE);
      read_word(12'h200, "R8 setup read");
      addr = 12'h201;
      tick(); chk("R8 old data held", {dout_valid, dout}, 5'h13);
      tick(); chk("R8 then invalid", {dout_valid, dout}, 5'h00);
      tick(); chk("R8 new data", {dout_valid, dout}, 5'h1E);
   endtask

   task automatic t_deselect();
      read_word(12'h201, "R2 setup read");
      sel_n = 1'b1;
      tick(); chk("R2 deselect zero", {dout_valid, dout}, 5'h00);
      addr = 12'h300; din = 4'hF; wen_a_n = 1'b0; wen_b_n = 1'b0;
      tick(); tick();
      wen_a_n = 1'b1; wen_b_n = 1'b1;
      tick(); chk_abort("R4 deselected strobe no abort", 1'b0);
      read_word(12'h300, "R4 deselected strobe no write");
   endtask

   task automatic t_single_enable();
      sel_n = 1'b0; addr = 12'h201; din = 4'h0;
      wen_a_n = 1'b0; wen_b_n = 1'b1;
      repeat (LAT + 1) tick();
      chk("R3 one enable low reads", {dout_valid, dout}, 5'h1E);
      wen_a_n = 1'b1; wen_b_n = 1'b0;
      tick(); tick();
      wen_b_n = 1'b1;
      tick();
      read_word(12'h201, "R3 word kept after single enable");
   endtask

   task automatic t_abort_addr();
      sel_n = 1'b0; addr = 12'h400; din = 4'h7; wen_a_n = 1'b0; wen_b_n = 1'b0;
      tick();
      addr = 12'h401;
      tick();
      wen_a_n = 1'b1; wen_b_n = 1'b1;
      tick(); chk_abort("R9 abort on address move", 1'b1);
      tick(); chk_abort("R9 abort lasts one cycle", 1'b0);
      read_word(12'h400, "R9 first address untouched");
      read_word(12'h401, "R9 second address untouched");
   endtask

   task automatic t_abort_sel();
      write_word(12'h500, 4'h2);
      sel_n = 1'b0; addr = 12'h500; din = 4'hB; wen_a_n = 1'b0; wen_b_n = 1'b0;
      tick();
      sel_n = 1'b1;
      tick();
      sel_n = 1'b0; wen_a_n = 1'b1; wen_b_n = 1'b1;
      tick(); chk_abort("R9 abort on select loss", 1'b1);
      read_word(12'h500, "R9 word kept after select loss");
   endtask

   task automatic t_random();
      logic [11:0] list [24];
      for (int i = 0; i < 24; i++) begin
         list[i] = 12'($urandom);
         write_word(list[i], 4'($urandom));
      end
      for (int i = 0; i < 24; i++) read_word(list[i], "R1 R5 random readback");
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) shadow[i] = 4'h0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_latency();
      t_recovery();
      t_late_data();
      t_hold();
      t_deselect();
      t_single_enable();
      t_abort_addr();
      t_abort_sel();
      t_random();
      go_idle();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule